// File: doc/BRIEF.md
# Hierarchical CCD Vertical Clock Sequencer

This block drives the six vertical transfer phases of a CCD image sensor, together with a horizontal blanking pulse and a black-level clamp pulse. The waveforms come from a four-level programmable hierarchy. A pattern sets the toggle points of all six phases inside one repeating window. A sequence places one pattern in a line by giving a start pixel, a repeat count and the blanking and clamp windows. A field is split into regions by line number, and each region plays one sequence. A mode list plays fields in any order, with repeats and skips allowed.

Configuration arrives through a plain write port (enable, address, data) into a shadow bank. The shadow bank is copied into the working bank only on a frame-start strobe, so the field being played never changes mid-way. The frame-start strobe also begins line 0 of the next field. The line strobe begins each later line. The block's clock is the pixel clock.

Top module: `vtiming_sequencer`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `vclk` is 0 and `hblk` and `clpob` are 0. Reset clears both the shadow and the working bank, so a frame strobe after reset with no writes leaves the outputs idle at 0.
- R2: Each phase output equals its pattern polarity XOR the parity of the toggle events so far in the line. A toggle event occurs in a cycle where the in-pattern position equals toggle A or toggle B of that phase, and it shows from the next cycle. When the two toggle positions are equal, the phase flips once.
- R3: A sequence's pattern window opens at the cycle whose line pixel count equals the start pixel. It plays the pattern `reps` times back to back, each occurrence lasting the pattern length in cycles. After the last occurrence the phases hold.
- R4: `hblk` is 1 while the line pixel count is below the sequence's blanking end. `clpob` is 1 while the count is at least the clamp start and below the clamp end.
- R5: The region index starts at 0 on each field. It advances on the line strobe that makes the line number equal the next region's start line. The last configured region lasts until the next frame strobe.
- R6: On each frame strobe with a nonzero mode count, playback moves to the next slot. After the last slot (count−1) it wraps to slot 0. The first frame after idle uses slot 0, and each slot names the field to play.
- R7: Writes go only to the shadow bank. The working bank takes a copy of the shadow bank on each frame strobe. A write in the same cycle as a frame strobe misses that copy and is used at the following strobe.
- R8: When a frame strobe commits a mode count of 0, the block goes idle. `vclk` then shows the polarities of pattern 0 and `hblk`/`clpob` stay 0. Line strobes are ignored until a frame strobe commits a nonzero count.
- R9: Write map (byte address, data lanes of 8 bits). The phase word of pattern g, phase p is at address 6g+p: toggle A in [7:0], toggle B in [15:8], polarity in [16]. The length of pattern g is at 64+g in [7:0]. Sequence s, word A is at 80+s: pattern in [3:0], start pixel in [15:8], reps in [23:16]. Sequence s, word B is at 96+s: blanking end in [7:0], clamp start in [15:8], clamp end in [23:16]. Field f, region r is at 112+8f+r: sequence in [3:0], start line in [15:8]. The region count of field f is at 112+8f+7 in [2:0]. The mode word is at 160: count in [2:0], slot k field in [4k+6:4k+4]. Phase bit k of `vclk` is phase k.
- R10: A frame strobe resets the line pixel count to 0, so the first cycle after the strobe edge is pixel 0 of line 0. A frame strobe takes priority over a line strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | Field boundary: commits shadow bank, steps mode slot, starts line 0 |
| line_stb | input | 1 | Starts the next line of the current field |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 8 | Configuration write address |
| wr_data | input | 32 | Configuration write data |
| vclk | output | 6 | Vertical phase outputs, bit k is phase k |
| hblk | output | 1 | Horizontal blanking pulse, active high |
| clpob | output | 1 | Black-level clamp pulse, active high |

## Verification
The delicate coincidence is a configuration write that lands in the same cycle as a frame strobe, where commit and write compete for the same bank. The bench pulses both at once, changing the mode count to zero. It then checks that the field started by that strobe still plays under the old mode, and that idling appears only at the following strobe. A second overlap is a mid-field write to a pattern already on the outputs. The bench judges it by the phase value after the next line strobe, which must not move until a frame strobe.

// File: rtl/vts_pkg.sv
package vts_pkg;

    // hierarchy dimensions
    localparam int NPH    = 6;
    localparam int NPAT   = 10;
    localparam int NSEQ   = 10;
    localparam int NREG   = 7;
    localparam int NFLD   = 6;
    localparam int NSLOT  = 7;

    // widths
    localparam int PIX_W  = 8;
    localparam int LINE_W = 8;
    localparam int REP_W  = 8;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int LANE_W = 8;

    localparam int PAT_IDX_W  = $clog2(NPAT);
    localparam int SEQ_IDX_W  = $clog2(NSEQ);
    localparam int FLD_IDX_W  = $clog2(NFLD);
    localparam int REG_IDX_W  = $clog2(NREG);
    localparam int REGCNT_W   = $clog2(NREG + 1);
    localparam int SLOT_W     = $clog2(NSLOT);
    localparam int SLOTCNT_W  = $clog2(NSLOT + 1);
    localparam int SLOT_PITCH = 4;

    // address map, each block aligned to 16 words
    localparam int A_PAT      = 0;
    localparam int A_PLEN     = ((NPAT * NPH + 15) / 16) * 16;
    localparam int A_SEQA     = A_PLEN + ((NPAT + 15) / 16) * 16;
    localparam int A_SEQB     = A_SEQA + ((NSEQ + 15) / 16) * 16;
    localparam int A_FLD      = A_SEQB + ((NSEQ + 15) / 16) * 16;
    localparam int FLD_STRIDE = NREG + 1;
    localparam int A_MODE     = A_FLD + NFLD * FLD_STRIDE;

    typedef struct packed {
        logic             pol;
        logic [PIX_W-1:0] tgb;
        logic [PIX_W-1:0] tga;
    } phase_cfg_t;

    typedef struct packed {
        phase_cfg_t [NPH-1:0] ph;
        logic [PIX_W-1:0]     len;
    } pat_cfg_t;

    typedef struct packed {
        logic [PAT_IDX_W-1:0] pat;
        logic [PIX_W-1:0]     start;
        logic [REP_W-1:0]     reps;
        logic [PIX_W-1:0]     hblk_end;
        logic [PIX_W-1:0]     clp_beg;
        logic [PIX_W-1:0]     clp_end;
    } seq_cfg_t;

    typedef struct packed {
        logic [SEQ_IDX_W-1:0] seq;
        logic [LINE_W-1:0]    start;
    } region_cfg_t;

    typedef struct packed {
        region_cfg_t [NREG-1:0] rg;
        logic [REGCNT_W-1:0]    nreg;
    } field_cfg_t;

    typedef struct packed {
        logic [SLOTCNT_W-1:0]                cnt;
        logic [NSLOT-1:0][FLD_IDX_W-1:0]     slot;
    } mode_cfg_t;

    typedef struct packed {
        pat_cfg_t   [NPAT-1:0] pat;
        seq_cfg_t   [NSEQ-1:0] seq;
        field_cfg_t [NFLD-1:0] fld;
        mode_cfg_t             mode;
    } cfg_bank_t;

    // out-of-range indices fall back to entry 0
    function automatic logic [PAT_IDX_W-1:0] pat_clip(input logic [PAT_IDX_W-1:0] i);
        return (int'(i) < NPAT) ? i : '0;
    endfunction

    function automatic logic [SEQ_IDX_W-1:0] seq_clip(input logic [SEQ_IDX_W-1:0] i);
        return (int'(i) < NSEQ) ? i : '0;
    endfunction

    function automatic logic [FLD_IDX_W-1:0] fld_clip(input logic [FLD_IDX_W-1:0] i);
        return (int'(i) < NFLD) ? i : '0;
    endfunction

    function automatic logic [REGCNT_W-1:0] nreg_eff(input logic [REGCNT_W-1:0] n);
        return (n == '0) ? REGCNT_W'(1) : n;
    endfunction

endpackage

// File: rtl/vts_cfg_bank.sv
module vts_cfg_bank
    import vts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    output cfg_bank_t         shadow_o,
    output cfg_bank_t         active_o
);

    cfg_bank_t shd_q;
    cfg_bank_t act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_q <= '0;
            act_q <= '0;
        end else begin
            if (commit) begin
                act_q <= shd_q;
            end
            if (wr_en) begin
                for (int g = 0; g < NPAT; g++) begin
                    for (int p = 0; p < NPH; p++) begin
                        if (wr_addr == ADDR_W'(A_PAT + g * NPH + p)) begin
                            shd_q.pat[g].ph[p].tga <= wr_data[0 +: PIX_W];
                            shd_q.pat[g].ph[p].tgb <= wr_data[LANE_W +: PIX_W];
                            shd_q.pat[g].ph[p].pol <= wr_data[2 * LANE_W];
                        end
                    end
                    if (wr_addr == ADDR_W'(A_PLEN + g)) begin
                        shd_q.pat[g].len <= wr_data[0 +: PIX_W];
                    end
                end
                for (int s = 0; s < NSEQ; s++) begin
                    if (wr_addr == ADDR_W'(A_SEQA + s)) begin
                        shd_q.seq[s].pat   <= wr_data[0 +: PAT_IDX_W];
                        shd_q.seq[s].start <= wr_data[LANE_W +: PIX_W];
                        shd_q.seq[s].reps  <= wr_data[2 * LANE_W +: REP_W];
                    end
                    if (wr_addr == ADDR_W'(A_SEQB + s)) begin
                        shd_q.seq[s].hblk_end <= wr_data[0 +: PIX_W];
                        shd_q.seq[s].clp_beg  <= wr_data[LANE_W +: PIX_W];
                        shd_q.seq[s].clp_end  <= wr_data[2 * LANE_W +: PIX_W];
                    end
                end
                for (int f = 0; f < NFLD; f++) begin
                    for (int r = 0; r < NREG; r++) begin
                        if (wr_addr == ADDR_W'(A_FLD + f * FLD_STRIDE + r)) begin
                            shd_q.fld[f].rg[r].seq   <= wr_data[0 +: SEQ_IDX_W];
                            shd_q.fld[f].rg[r].start <= wr_data[LANE_W +: LINE_W];
                        end
                    end
                    if (wr_addr == ADDR_W'(A_FLD + f * FLD_STRIDE + NREG)) begin
                        shd_q.fld[f].nreg <= wr_data[0 +: REGCNT_W];
                    end
                end
                if (wr_addr == ADDR_W'(A_MODE)) begin
                    shd_q.mode.cnt <= wr_data[0 +: SLOTCNT_W];
                    for (int k = 0; k < NSLOT; k++) begin
                        shd_q.mode.slot[k] <= wr_data[SLOT_PITCH * (k + 1) +: FLD_IDX_W];
                    end
                end
            end
        end
    end

    // lanes of the data word that no field decodes
    logic unused_wdata;
    assign unused_wdata = ^wr_data;

    assign shadow_o = shd_q;
    assign active_o = act_q;

endmodule

// File: rtl/vts_walker.sv
module vts_walker
    import vts_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_stb,
    input  logic                 line_stb,
    input  mode_cfg_t            next_mode,
    input  field_cfg_t           cur_fld,
    output logic                 running_o,
    output logic [SLOT_W-1:0]    slot_o,
    output logic [FLD_IDX_W-1:0] field_o,
    output logic [REG_IDX_W-1:0] region_o,
    output logic [LINE_W-1:0]    line_o
);

    logic                 running_q;
    logic [SLOT_W-1:0]    slot_q;
    logic [FLD_IDX_W-1:0] field_q;
    logic [REG_IDX_W-1:0] region_q;
    logic [LINE_W-1:0]    line_q;

    logic [SLOT_W-1:0]    slot_nxt;
    logic [REG_IDX_W-1:0] region_inc;
    logic [LINE_W-1:0]    line_inc;
    logic                 region_adv;

    always_comb begin
        if (!running_q ||
            ((SLOTCNT_W + 1)'(slot_q) + (SLOTCNT_W + 1)'(1)) >= (SLOTCNT_W + 1)'(next_mode.cnt)) begin
            slot_nxt = '0;
        end else begin
            slot_nxt = slot_q + SLOT_W'(1);
        end
    end

    assign region_inc = region_q + REG_IDX_W'(1);
    assign line_inc   = line_q + LINE_W'(1);

    always_comb begin
        region_adv = 1'b0;
        if (int'(region_q) < NREG - 1) begin
            if ((REGCNT_W'(region_inc) < nreg_eff(cur_fld.nreg)) &&
                (line_inc == cur_fld.rg[region_inc].start)) begin
                region_adv = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            slot_q    <= '0;
            field_q   <= '0;
            region_q  <= '0;
            line_q    <= '0;
        end else if (frame_stb) begin
            line_q   <= '0;
            region_q <= '0;
            if (next_mode.cnt == '0) begin
                running_q <= 1'b0;
                slot_q    <= '0;
            end else begin
                running_q <= 1'b1;
                slot_q    <= slot_nxt;
                field_q   <= fld_clip(next_mode.slot[slot_nxt]);
            end
        end else if (line_stb && running_q) begin
            line_q <= line_inc;
            if (region_adv) begin
                region_q <= region_inc;
            end
        end
    end

    // sequence selections are used by the top, not here
    logic unused_fld;
    assign unused_fld = ^cur_fld;

    assign running_o = running_q;
    assign slot_o    = slot_q;
    assign field_o   = field_q;
    assign region_o  = region_q;
    assign line_o    = line_q;

endmodule

// File: rtl/vts_line_engine.sv
module vts_line_engine
    import vts_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           line_start,
    input  logic           running,
    input  seq_cfg_t       seq,
    input  pat_cfg_t       pat,
    input  logic [NPH-1:0] idle_pol,
    output logic [NPH-1:0] v_o,
    output logic           hblk_o,
    output logic           clpob_o
);

    logic [PIX_W-1:0] pix_q;
    logic [PIX_W-1:0] pos_q;
    logic [REP_W-1:0] rep_q;
    logic [NPH-1:0]   tog_q;

    logic [PIX_W-1:0] len_eff;
    logic             occ_last;
    logic             in_win;
    logic [NPH-1:0]   hit;
    logic [NPH-1:0]   pol_vec;

    assign len_eff  = (pat.len == '0) ? PIX_W'(1) : pat.len;
    assign occ_last = (pos_q == len_eff - PIX_W'(1));
    assign in_win   = (pix_q >= seq.start) && (rep_q < seq.reps);

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        assign hit[p]     = (pos_q == pat.ph[p].tga) || (pos_q == pat.ph[p].tgb);
        assign pol_vec[p] = pat.ph[p].pol;
    end

    always_ff @(posedge clk) begin
        if (rst || line_start) begin
            pix_q <= '0;
            pos_q <= '0;
            rep_q <= '0;
            tog_q <= '0;
        end else begin
            if (pix_q != '1) begin
                pix_q <= pix_q + PIX_W'(1);
            end
            if (in_win) begin
                tog_q <= tog_q ^ hit;
                if (occ_last) begin
                    pos_q <= '0;
                    rep_q <= rep_q + REP_W'(1);
                end else begin
                    pos_q <= pos_q + PIX_W'(1);
                end
            end
        end
    end

    logic unused_seq;
    assign unused_seq = ^seq.pat;

    assign v_o     = running ? (pol_vec ^ tog_q) : idle_pol;
    assign hblk_o  = running && (pix_q < seq.hblk_end);
    assign clpob_o = running && (pix_q >= seq.clp_beg) && (pix_q < seq.clp_end);

endmodule

// File: rtl/vtiming_sequencer.sv
module vtiming_sequencer
    import vts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  logic              line_stb,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NPH-1:0]    vclk,
    output logic              hblk,
    output logic              clpob
);

    cfg_bank_t            shd;
    cfg_bank_t            act;
    logic                 running;
    logic [SLOT_W-1:0]    slot_idx;
    logic [FLD_IDX_W-1:0] field_idx;
    logic [REG_IDX_W-1:0] region_idx;
    logic [LINE_W-1:0]    line_num;

    field_cfg_t           cur_fld;
    seq_cfg_t             cur_seq;
    pat_cfg_t             cur_pat;
    logic [NPH-1:0]       idle_pol;
    logic                 line_start;

    vts_cfg_bank bank_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .commit   (frame_stb),
        .shadow_o (shd),
        .active_o (act)
    );

    assign cur_fld = act.fld[field_idx];
    assign cur_seq = act.seq[seq_clip(cur_fld.rg[region_idx].seq)];
    assign cur_pat = act.pat[pat_clip(cur_seq.pat)];

    for (genvar p = 0; p < NPH; p++) begin : g_idle
        assign idle_pol[p] = act.pat[0].ph[p].pol;
    end

    vts_walker walk_i (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .line_stb  (line_stb),
        .next_mode (shd.mode),
        .cur_fld   (cur_fld),
        .running_o (running),
        .slot_o    (slot_idx),
        .field_o   (field_idx),
        .region_o  (region_idx),
        .line_o    (line_num)
    );

    assign line_start = frame_stb || (line_stb && running);

    vts_line_engine eng_i (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .running    (running),
        .seq        (cur_seq),
        .pat        (cur_pat),
        .idle_pol   (idle_pol),
        .v_o        (vclk),
        .hblk_o     (hblk),
        .clpob_o    (clpob)
    );

    // bank bits read only through the bound checker
    logic unused_cfg;
    assign unused_cfg = ^{act.mode, shd, line_num};

endmodule

// File: rtl/vts_checker.sv
module vts_checker
    import vts_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 frame_stb,
    input logic                 line_stb,
    input cfg_bank_t            shd,
    input cfg_bank_t            act,
    input logic                 running,
    input logic [SLOT_W-1:0]    slot_idx,
    input logic [REG_IDX_W-1:0] region_idx,
    input field_cfg_t           cur_fld,
    input logic [NPH-1:0]       vclk,
    input logic                 hblk,
    input logic                 clpob
);

    // R7: the working bank only moves on a field boundary
    a_r7_bank_frozen: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(act));

    // R6: the playing slot never reaches the committed slot count
    a_r6_slot_bound: assert property (@(posedge clk) disable iff (rst)
        running |-> (SLOTCNT_W'(slot_idx) < act.mode.cnt));

    // R5: the region index stays inside the field's region count
    a_r5_region_bound: assert property (@(posedge clk) disable iff (rst)
        running |-> (REGCNT_W'(region_idx) < nreg_eff(cur_fld.nreg)));

    // R8: committing an empty mode silences both horizontal pulses
    a_r8_idle_blank: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && shd.mode.cnt == '0) |=> (!hblk && !clpob));

    // R8: line strobes while idle leave the phases untouched
    a_r8_idle_line_ignored: assert property (@(posedge clk) disable iff (rst)
        (!running && line_stb && !frame_stb) |=> $stable(vclk));

endmodule

bind vtiming_sequencer vts_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .frame_stb  (frame_stb),
    .line_stb   (line_stb),
    .shd        (shd),
    .act        (act),
    .running    (running),
    .slot_idx   (slot_idx),
    .region_idx (region_idx),
    .cur_fld    (cur_fld),
    .vclk       (vclk),
    .hblk       (hblk),
    .clpob      (clpob)
);

// File: tb/vtiming_sequencer_tb_top.sv
`timescale 1ns/1ps
module vtiming_sequencer_tb_top;

    localparam real CLK_PERIOD = 8.0;
    localparam int  WATCHDOG   = 50000;
    localparam int  NVEC       = 12;

    // each entry {vclk[5:0], hblk, clpob} for pixel c of the first line
    localparam logic [7:0] LINE0_VEC [NVEC] = '{
        8'h2A, 8'h2A, 8'h2A, 8'h2C, 8'h24, 8'h20,
        8'h30, 8'h34, 8'h3C, 8'h38, 8'h29, 8'h29
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_stb = 1'b0;
    logic        line_stb = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  vclk;
    logic        hblk;
    logic        clpob;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    vtiming_sequencer dut_i (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .line_stb  (line_stb),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .vclk      (vclk),
        .hblk      (hblk),
        .clpob     (clpob)
    );

    task automatic chk(input string req, input logic [5:0] ev, input logic eh, input logic ec);
        n_chk++;
        if ({vclk, hblk, clpob} !== {ev, eh, ec}) begin
            n_fail++;
            $display("FAIL %s: vclk=%h hblk=%b clpob=%b, expected vclk=%h hblk=%b clpob=%b",
                     req, vclk, hblk, clpob, ev, eh, ec);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic pulse_frame();
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic pulse_line();
        line_stb = 1'b1;
        @(negedge clk);
        line_stb = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 in reset", 6'h00, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", 6'h00, 1'b0, 1'b0);

        // R9 map: pattern 0 phases and length
        wr(8'd0, 32'h0000_0200);
        wr(8'd1, 32'h0001_0101);
        wr(8'd2, 32'h0000_0903);
        wr(8'd3, 32'h0001_0F0F);
        wr(8'd4, 32'h0000_0F0F);
        wr(8'd5, 32'h0000_0F0F);
        wr(8'd64, 32'h0000_0004);
        // pattern 1: all phases high, no toggles
        for (int p = 0; p < 6; p++) wr(8'(6 + p), 32'h0001_0F0F);
        wr(8'd65, 32'h0000_0004);
        // sequences
        wr(8'd80, 32'h0002_0200);
        wr(8'd96, 32'h000C_0A03);
        wr(8'd81, 32'h0001_0001);
        wr(8'd97, 32'h0000_0000);
        // field 0: region 0 seq 0, region 1 seq 1 from line 2
        wr(8'd112, 32'h0000_0000);
        wr(8'd113, 32'h0000_0201);
        wr(8'd119, 32'h0000_0002);
        // field 1: one region on seq 1
        wr(8'd120, 32'h0000_0001);
        wr(8'd127, 32'h0000_0001);
        // mode: one slot, field 0
        wr(8'd160, 32'h0000_0001);

        chk("R7 shadow not live before frame", 6'h00, 1'b0, 1'b0);

        // line 0 of field 0 walked against the vector table (R2 R3 R4 R10)
        pulse_frame();
        for (int c = 0; c < NVEC; c++) begin
            chk("R2 R3 R4 R10 line0 vector", LINE0_VEC[c][7:2], LINE0_VEC[c][1], LINE0_VEC[c][0]);
            @(negedge clk);
        end

        pulse_line();
        chk("R5 line1 stays in region 0", 6'h0A, 1'b1, 1'b0);
        pulse_line();
        chk("R5 line2 enters region 1", 6'h3F, 1'b0, 1'b0);
        pulse_line();
        chk("R5 last region persists", 6'h3F, 1'b0, 1'b0);

        // mid-field writes: pattern 1 phase 0 low, mode {cnt 3: 1,0,0}
        wr(8'd6, 32'h0000_0F0F);
        wr(8'd160, 32'h0000_0013);
        pulse_line();
        chk("R7 mid-field write not applied", 6'h3F, 1'b0, 1'b0);

        pulse_frame();
        chk("R6 slot1 field0", 6'h0A, 1'b1, 1'b0);
        pulse_frame();
        chk("R6 slot2 field0", 6'h0A, 1'b1, 1'b0);
        pulse_frame();
        chk("R6 wrap slot0 field1", 6'h3E, 1'b0, 1'b0);
        pulse_frame();
        chk("R6 slot1 field0 again", 6'h0A, 1'b1, 1'b0);

        // write coincident with frame strobe: mode count 0
        frame_stb = 1'b1;
        wr(8'd160, 32'h0000_0000);
        frame_stb = 1'b0;
        chk("R7 coincident write misses commit", 6'h0A, 1'b1, 1'b0);

        pulse_frame();
        chk("R8 idle after empty mode", 6'h0A, 1'b0, 1'b0);
        pulse_line();
        chk("R8 line strobe ignored while idle", 6'h0A, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        chk("R8 idle holds", 6'h0A, 1'b0, 1'b0);

        // frame and line strobe together: frame wins, pixel 0 of line 0
        wr(8'd160, 32'h0000_0001);
        line_stb = 1'b1;
        pulse_frame();
        line_stb = 1'b0;
        chk("R10 frame beats line c0", 6'h0A, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk("R10 frame beats line c3", 6'h0B, 1'b0, 1'b0);

        // reset mid-run
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset mid-run", 6'h00, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        pulse_frame();
        chk("R1 banks cleared by reset", 6'h00, 1'b0, 1'b0);

        finish_run();
    end

endmodule